// File: doc/BRIEF.md
# Sequential Parameter Refresh Controller

This block holds a bank of analog-style stored parameters, which slowly leak or drift, close to a set of reference values kept in a separate memory. It runs in the background. It steps through the parameter addresses in a fixed round-robin order and stays on each address for a fixed dwell time. Near the end of each dwell it compares the probed value of the selected parameter with its reference. It then fires at most one fixed-size up or down correction pulse, chosen by the sign of the difference.

The correction uses the same one-step increment/decrement pulse path that a learning update would use, so the surrounding logic needs no second write mechanism. Normal operation is never blocked. The dwell per parameter is derived as `PASS_CYCLES / N_PARAM` clock cycles. With the default 200 MHz clock, a pass period of 100 ms gives a 10 Hz refresh of every parameter, which is enough to hold roughly 8 bits of effective resolution against typical drift. A difference of at most one LSB in either direction is treated as in range, and no pulse is sent for it.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is asserted, `sel_addr` is 0, and `step_pulse` and `step_up` are 0.
- R2: After reset, each address is held on `sel_addr` for exactly `PASS_CYCLES / N_PARAM` clock cycles, and then advances by one.
- R3: After address `N_PARAM-1`, the next address is 0.
- R4: `step_pulse` is high for at most one cycle per visit, and only in the last cycle of the visit, while `sel_addr` still shows the corrected parameter.
- R5: If the reference exceeds the probed value by 2 or more, the visit ends with a pulse and `step_up` = 1 (increment).
- R6: If the probed value exceeds the reference by 2 or more, the visit ends with a pulse and `step_up` = 0 (decrement).
- R7: If the probed value and the reference differ by 0 or 1 in either direction, no pulse is issued for that visit.
- R8: The decision uses only the inputs present in the second-to-last cycle of the visit. Input values in other cycles of the visit have no effect on the pulse.
- R9: In closed loop, the refresh keeps every stored value within 3 LSB of its reference. This holds when the storage drifts by single steps at random, at most once per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_val | input | VAL_W | Probed value of the parameter at `sel_addr` (unsigned) |
| ref_val | input | VAL_W | Reference value for the parameter at `sel_addr` (unsigned) |
| sel_addr | output | clog2(N_PARAM) | Address of the parameter being visited |
| step_up | output | 1 | Direction of the correction: 1 = increment, 0 = decrement; valid with `step_pulse` |
| step_pulse | output | 1 | One-cycle enable for a single fixed-size correction step |

## Verification
The assertions assume that the probe and reference inputs are known, unsigned values that belong to the address currently on `sel_addr`. They also assume that the dwell is at least two cycles. The bench holds each visit's inputs steady and changes them only on the falling clock edge. It replaces them for exactly one cycle when it targets the decision slot. In closed loop, the bench's storage model drives the probe from the selected address. It applies its drift on a slow, fixed interval, so that the error never runs ahead of one correction per pass.

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int N_PARAM     = 48,
  parameter int VAL_W       = 10,
  parameter int PASS_CYCLES = 20_000_000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [VAL_W-1:0]                     probe_val,
  input  logic [VAL_W-1:0]                     ref_val,
  output logic [(N_PARAM>1?$clog2(N_PARAM):1)-1:0] sel_addr,
  output logic                                 step_up,
  output logic                                 step_pulse
);

  localparam int DWELL = PASS_CYCLES / N_PARAM;
  localparam int AW    = N_PARAM > 1 ? $clog2(N_PARAM) : 1;
  localparam int CW    = DWELL > 1 ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST   = CW'(DWELL - 1);
  localparam logic [CW-1:0] DECIDE = CW'(DWELL - 2);
  localparam logic [AW-1:0] TOP    = AW'(N_PARAM - 1);

  logic [CW-1:0] tick;
  logic [AW-1:0] addr_q;
  logic          pulse_q, up_q;

  wire [VAL_W:0] p_ext = {1'b0, probe_val};
  wire [VAL_W:0] r_ext = {1'b0, ref_val};
  wire too_low   = (p_ext + (VAL_W+1)'(1)) < r_ext;
  wire too_high  = p_ext > (r_ext + (VAL_W+1)'(1));
  wire at_decide = (tick == DECIDE);
  wire at_last   = (tick == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick   <= '0;
      addr_q <= '0;
    end else if (at_last) begin
      tick   <= '0;
      addr_q <= (addr_q == TOP) ? '0 : addr_q + 1'b1;
    end else begin
      tick   <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      pulse_q <= at_decide && (too_low || too_high);
      if (at_decide && too_low)       up_q <= 1'b1;
      else if (at_decide && too_high) up_q <= 1'b0;
    end
  end

  assign sel_addr   = addr_q;
  assign step_pulse = pulse_q;
  assign step_up    = up_q;

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> $stable(sel_addr));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && sel_addr != TOP) |=> sel_addr == AW'($past(sel_addr) + 1'b1));

  p_addr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && sel_addr == TOP) |=> sel_addr == '0);

  p_pulse_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> at_last);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);

  p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decide && ref_val > probe_val && (ref_val - probe_val) > VAL_W'(1))
      |=> (step_pulse && step_up));

  p_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decide && probe_val > ref_val && (probe_val - ref_val) > VAL_W'(1))
      |=> (step_pulse && !step_up));

  p_deadband_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_decide && ((ref_val >= probe_val) ? (ref_val - probe_val) <= VAL_W'(1)
                                          : (probe_val - ref_val) <= VAL_W'(1)))
      |=> !step_pulse);

endmodule

// File: tb/test_refresh_sequencer.sv
`timescale 1ns/1ps
module test_refresh_sequencer;
  localparam int N     = 4;
  localparam int VW    = 8;
  localparam int PASS  = 32;
  localparam int DWELL = PASS / N;
  localparam int NV    = 13;

  localparam int VP [NV] = '{10, 200, 100, 101,  99, 102,  98,   0, 255, 0, 255, 0, 255};
  localparam int VR [NV] = '{50,  20, 100, 100, 100, 100, 100, 255,   0, 1, 254, 2, 253};
  localparam int VE [NV] = '{ 1,   1,   0,   0,   0,   1,   1,   1,   1, 0,   0, 1,   1};
  localparam int VU [NV] = '{ 1,   0,   0,   0,   0,   0,   1,   1,   0, 0,   0, 1,   0};
  localparam int REFS [N] = '{100, 150, 60, 200};
  localparam int OFFS [N] = '{10, -10, 7, -5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [VW-1:0] probe_drv = '0, ref_drv = '0;
  logic [VW-1:0] probe_val, ref_val;
  logic [1:0] sel_addr;
  logic step_up, step_pulse;
  logic loop_mode = 1'b0;
  logic done = 1'b0;
  int   store [N];
  int   drift_cnt;
  int   applied = 0, bad = 0;

  always #2.5 clk = ~clk;

  assign probe_val = loop_mode ? VW'(store[sel_addr]) : probe_drv;
  assign ref_val   = loop_mode ? VW'(REFS[sel_addr])  : ref_drv;

  refresh_sequencer #(.N_PARAM(N), .VAL_W(VW), .PASS_CYCLES(PASS)) i_refresh_sequencer (
    .clk(clk), .rst_n(rst_n), .probe_val(probe_val), .ref_val(ref_val),
    .sel_addr(sel_addr), .step_up(step_up), .step_pulse(step_pulse));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) store[j] <= REFS[j] + OFFS[j];
      drift_cnt <= 0;
    end else if (loop_mode) begin
      drift_cnt <= (drift_cnt == 2*PASS-1) ? 0 : drift_cnt + 1;
      for (int j = 0; j < N; j++) begin
        int nv;
        nv = store[j];
        if (step_pulse && sel_addr == 2'(j)) nv = nv + (step_up ? 1 : -1);
        if (drift_cnt == 2*PASS-1 && ($urandom % N) == 0)
          nv = nv + (($urandom % 2) == 1 ? 1 : -1);
        store[j] <= nv;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic visit(input int p_e, input int r_e, input int p_d, input int r_d,
                       input int ep, input int eu, input int ea, input string tag);
    probe_drv = VW'(p_e); ref_drv = VW'(r_e);
    check(sel_addr == 2'(ea), ea == 0 ? "R3 wrap/addr" : "R2 addr", int'(sel_addr), ea);
    check(step_pulse == 1'b0, "R4 pulse outside last cycle", int'(step_pulse), 0);
    repeat (DWELL-2) @(posedge clk);
    @(negedge clk);
    probe_drv = VW'(p_d); ref_drv = VW'(r_d);
    @(negedge clk);
    probe_drv = VW'(p_e); ref_drv = VW'(r_e);
    check(step_pulse == 1'(ep), tag, int'(step_pulse), ep);
    check(sel_addr == 2'(ea), "R4 addr held at pulse", int'(sel_addr), ea);
    if (ep == 1) check(step_up == 1'(eu), tag, int'(step_up), eu);
    @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check(sel_addr == 2'd0, "R1 reset addr", int'(sel_addr), 0);
    check(step_pulse == 1'b0, "R1 reset pulse", int'(step_pulse), 0);
    check(step_up == 1'b0, "R1 reset dir", int'(step_up), 0);
    rst_n = 1'b1;
    v = 0;
    for (int i = 0; i < NV; i++) begin
      string t;
      t = VE[i] == 0 ? "R7 deadband" : (VU[i] == 1 ? "R5 increment" : "R6 decrement");
      visit(VP[i], VR[i], VP[i], VR[i], VE[i], VU[i], v % N, t);
      v++;
    end
    visit(10, 200, 50, 50, 0, 0, v % N, "R8 only decide slot counts (in band)");  v++;
    visit(50, 50, 10, 200, 1, 1, v % N, "R8 only decide slot counts (low)");      v++;
    visit(50, 50, 200, 10, 1, 0, v % N, "R8 only decide slot counts (high)");     v++;
    @(negedge clk); rst_n = 1'b0;
    loop_mode = 1'b1;
    @(negedge clk);
    check(sel_addr == 2'd0, "R1 reset addr again", int'(sel_addr), 0);
    rst_n = 1'b1;
    repeat (40*PASS) @(posedge clk);
    for (int k = 0; k < 200; k++) begin
      repeat (PASS) @(posedge clk);
      @(negedge clk);
      for (int j = 0; j < N; j++) begin
        int e;
        e = store[j] - REFS[j];
        check(e <= 3 && e >= -3, "R9 closed-loop error", store[j], REFS[j]);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule